// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a host bus a set of general-purpose parallel lines. There are two full-width ports, A and B, and a third port, C. Port C is split into an upper half and a lower half, and each half has its own direction. The host sees four byte-wide locations through an active-low chip select, active-low read and write strobes and a two-bit register address. One location is a control register. A single control word sets the direction of all four sections at once.

Only plain input/output operation is built. A port section set as an output drives the value in its output latch. A port section set as an input reports its pins after a synchronizer. A control word that does not carry the set flag is dropped. A control word that asks for a handshake mode is also dropped. The pads are modelled as separate data-out and output-enable vectors, not as tri-state nets.

Top module: `ppi_core`

## Requirements
- R1: After reset, every section is an input: all output-enable vectors are 0, all output latches are 0, and a read of the control location returns 0x9B.
- R2: The address selects the target: 0 is port A, 1 is port B, 2 is the whole of port C, and 3 is the control register. There is no separate address for either half of port C.
- R3: An accepted control word sets the directions as follows, with 1 meaning input: bit 4 sets port A, bit 3 sets the upper half of C, bit 1 sets port B, and bit 0 sets the lower half of C. An output section drives all-ones on its output enable; an input section drives all-zeros. For example, 0x98 makes A and upper C inputs, and 0x82 makes only B an input.
- R4: A control write with bit 7 at 0 has no effect on the configuration or on the latches.
- R5: A control write with bit 7 at 1 and a handshake mode selected has no effect on the configuration or on the latches. A handshake mode is selected when bits 6:5 are not 00 or when bit 2 is 1.
- R6: An accepted control write clears every output latch to 0 in the same clock edge.
- R7: A port write stores the whole data byte in that port's latch. A write to port C updates both halves in the same edge. The data-out vectors always show the latch contents.
- R8: A read of an output section returns its latch. A read of an input section returns its pin value after SYNC_STAGES clock edges of synchronization. For port C, each half is chosen separately.
- R9: Accesses take effect only while chip select is low. The read-data enable is high only when both chip select and read are low, and the read data is 0 otherwise.
- R10: A read of the control location returns the current configuration as a control word, with bit 7 at 1, the mode bits at 0, and the direction bits set as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, sampled on the clock edge |
| addr | input | 2 | Location select |
| wdata | input | PORT_W | Write data from host |
| rdata | output | PORT_W | Read data to host |
| rdata_oe | output | 1 | Host data bus drive enable |
| pa_in | input | PORT_W | Port A pin inputs |
| pa_out | output | PORT_W | Port A latch value |
| pa_oe | output | PORT_W | Port A output enables |
| pb_in | input | PORT_W | Port B pin inputs |
| pb_out | output | PORT_W | Port B latch value |
| pb_oe | output | PORT_W | Port B output enables |
| pc_in | input | PORT_W | Port C pin inputs |
| pc_out | output | PORT_W | Port C latch value |
| pc_oe | output | PORT_W | Port C output enables, per half |

## Verification
The bench sets the two halves of port C to opposite directions and reads the port as one byte. A design that chose the read source per port instead of per half would return only latch bits or only pin bits. It sends control words that lack the set flag or that ask for a handshake mode. A design that decoded those words would change the directions or clear the latches, and the bench sees this on the enables and on the control readback. It reads an input pin one edge and then two edges after the pin changes, which catches a synchronizer that is too short or too long. It also drives the write strobe while chip select is high; a design that ignored chip select would overwrite a latch.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

   // Direction of each port section, 1 = input
   typedef struct packed {
      logic a_in;
      logic cu_in;
      logic b_in;
      logic cl_in;
   } ppi_dir_t;

   localparam int CW_W        = 8;
   localparam int CW_SET_BIT  = 7;
   localparam int CW_A_DIR    = 4;
   localparam int CW_CU_DIR   = 3;
   localparam int CW_B_MODE   = 2;
   localparam int CW_B_DIR    = 1;
   localparam int CW_CL_DIR   = 0;

   localparam logic [1:0] LOC_A    = 2'd0;
   localparam logic [1:0] LOC_B    = 2'd1;
   localparam logic [1:0] LOC_C    = 2'd2;
   localparam logic [1:0] LOC_CTRL = 2'd3;

   localparam ppi_dir_t DIR_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

   function automatic logic cw_accepted(input logic [CW_W-1:0] cw);
      return cw[CW_SET_BIT] && (cw[6:5] == 2'b00) && !cw[CW_B_MODE];
   endfunction

   function automatic ppi_dir_t cw_to_dir(input logic [CW_W-1:0] cw);
      ppi_dir_t d;
      d.a_in  = cw[CW_A_DIR];
      d.cu_in = cw[CW_CU_DIR];
      d.b_in  = cw[CW_B_DIR];
      d.cl_in = cw[CW_CL_DIR];
      return d;
   endfunction

   function automatic logic [CW_W-1:0] dir_to_cw(input ppi_dir_t d);
      logic [CW_W-1:0] cw;
      cw             = '0;
      cw[CW_SET_BIT] = 1'b1;
      cw[CW_A_DIR]   = d.a_in;
      cw[CW_CU_DIR]  = d.cu_in;
      cw[CW_B_DIR]   = d.b_in;
      cw[CW_CL_DIR]  = d.cl_in;
      return cw;
   endfunction

endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("ppi_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("ppi_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_flops
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end

endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
   import ppi_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [CW_W-1:0] cw,
   output ppi_dir_t        dir,
   output logic            cfg_load
);

   ppi_dir_t dir_q;

   assign cfg_load = wr_en && cw_accepted(cw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dir_q <= DIR_RESET;
      else if (cfg_load) dir_q <= cw_to_dir(cw);
   end

   assign dir = dir_q;

   // R4: a write without the set flag leaves the configuration alone
   p_no_flag_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cw[CW_SET_BIT]) |=> $stable(dir_q));

   // R5: a write selecting a handshake mode leaves the configuration alone
   p_bad_mode_keeps_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cw[CW_SET_BIT] && ((cw[6:5] != 2'b00) || cw[CW_B_MODE])) |=> $stable(dir_q));

endmodule

// File: rtl/ppi_lane.sv
module ppi_lane #(
   parameter int W           = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         is_input,
   input  logic         wr_en,
   input  logic         clr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val
);

   logic [W-1:0] latch_q;
   logic [W-1:0] pin_sync;

   ppi_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     latch_q <= '0;
      else if (clr)   latch_q <= '0;
      else if (wr_en) latch_q <= wdata;
   end

   assign pin_out = latch_q;
   assign pin_oe  = {W{~is_input}};
   assign rd_val  = is_input ? pin_sync : latch_q;

   // R7: the latch changes only on a write or a clear
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr) |=> $stable(latch_q));

   // R6: an accepted configuration write empties the latch
   p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pin_out == '0));

endmodule

// File: rtl/ppi_core.sv
module ppi_core
   import ppi_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] rdata,
   output logic              rdata_oe,
   input  logic [PORT_W-1:0] pa_in,
   output logic [PORT_W-1:0] pa_out,
   output logic [PORT_W-1:0] pa_oe,
   input  logic [PORT_W-1:0] pb_in,
   output logic [PORT_W-1:0] pb_out,
   output logic [PORT_W-1:0] pb_oe,
   input  logic [PORT_W-1:0] pc_in,
   output logic [PORT_W-1:0] pc_out,
   output logic [PORT_W-1:0] pc_oe
);

   localparam int HALF_W = PORT_W / 2;

   if (PORT_W < CW_W || (PORT_W % 2) != 0) begin : g_bad_width
      $error("ppi_core: PORT_W must be even and at least the control word width");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("ppi_core: SYNC_STAGES must not be negative");
   end

   logic     wr_sel;
   logic     rd_sel;
   logic     wr_a, wr_b, wr_c, wr_ctrl;
   logic     cfg_load;
   ppi_dir_t dir;

   logic [PORT_W-1:0] a_rd, b_rd;
   logic [HALF_W-1:0] cu_rd, cl_rd;
   logic [PORT_W-1:0] rd_mux;

   assign wr_sel  = !cs_n && !wr_n;
   assign rd_sel  = !cs_n && !rd_n;
   assign wr_a    = wr_sel && (addr == LOC_A);
   assign wr_b    = wr_sel && (addr == LOC_B);
   assign wr_c    = wr_sel && (addr == LOC_C);
   assign wr_ctrl = wr_sel && (addr == LOC_CTRL);

   ppi_ctrl_reg u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ctrl),
      .cw       (wdata[CW_W-1:0]),
      .dir      (dir),
      .cfg_load (cfg_load)
   );

   ppi_lane #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_lane_a (
      .clk (clk), .rst_n (rst_n), .is_input (dir.a_in),
      .wr_en (wr_a), .clr (cfg_load), .wdata (wdata),
      .pin_in (pa_in), .pin_out (pa_out), .pin_oe (pa_oe), .rd_val (a_rd)
   );

   ppi_lane #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_lane_b (
      .clk (clk), .rst_n (rst_n), .is_input (dir.b_in),
      .wr_en (wr_b), .clr (cfg_load), .wdata (wdata),
      .pin_in (pb_in), .pin_out (pb_out), .pin_oe (pb_oe), .rd_val (b_rd)
   );

   ppi_lane #(.W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) u_lane_cu (
      .clk (clk), .rst_n (rst_n), .is_input (dir.cu_in),
      .wr_en (wr_c), .clr (cfg_load), .wdata (wdata[PORT_W-1:HALF_W]),
      .pin_in (pc_in[PORT_W-1:HALF_W]), .pin_out (pc_out[PORT_W-1:HALF_W]),
      .pin_oe (pc_oe[PORT_W-1:HALF_W]), .rd_val (cu_rd)
   );

   ppi_lane #(.W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) u_lane_cl (
      .clk (clk), .rst_n (rst_n), .is_input (dir.cl_in),
      .wr_en (wr_c), .clr (cfg_load), .wdata (wdata[HALF_W-1:0]),
      .pin_in (pc_in[HALF_W-1:0]), .pin_out (pc_out[HALF_W-1:0]),
      .pin_oe (pc_oe[HALF_W-1:0]), .rd_val (cl_rd)
   );

   always_comb begin
      unique case (addr)
         LOC_A:   rd_mux = a_rd;
         LOC_B:   rd_mux = b_rd;
         LOC_C:   rd_mux = {cu_rd, cl_rd};
         default: rd_mux = PORT_W'(dir_to_cw(dir));
      endcase
   end

   assign rdata_oe = rd_sel;
   assign rdata    = rd_sel ? rd_mux : '0;

   // R3: each output-enable group is uniform across its section
   p_oe_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pa_oe == '0) || (pa_oe == '1)) && ((pb_oe == '0) || (pb_oe == '1)));

   // R10: control readback always shows the set flag and basic mode
   p_cfg_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_oe && addr == LOC_CTRL) |-> (rdata[7] && rdata[6:5] == 2'b00 && !rdata[2]));

   // R9: nothing is written while the chip is not selected
   p_no_write_unselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

endmodule

// File: tb/ppi_core_tb.sv
module ppi_core_tb;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         rdata_oe;
   logic [W-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
   logic [W-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ppi_core #(.PORT_W(W), .SYNC_STAGES(2)) u_dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
      .addr (addr), .wdata (wdata), .rdata (rdata), .rdata_oe (rdata_oe),
      .pa_in (pa_in), .pa_out (pa_out), .pa_oe (pa_oe),
      .pb_in (pb_in), .pb_out (pb_out), .pb_oe (pb_oe),
      .pc_in (pc_in), .pc_out (pc_out), .pc_oe (pc_oe)
   );

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d, output logic oe);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      #1;
      d = rdata; oe = rdata_oe;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic t_reset;
      logic [W-1:0] d; logic oe;
      check(pa_oe, 8'h00, "R1 pa_oe after reset");
      check(pb_oe | pc_oe, 8'h00, "R1 pb/pc oe after reset");
      check(pa_out | pb_out | pc_out, 8'h00, "R1 latches after reset");
      check({7'd0, rdata_oe}, 8'h00, "R9 rdata_oe idle");
      bus_read(2'd3, d, oe);
      check(d, 8'h9B, "R1 R10 control readback after reset");
      check({7'd0, oe}, 8'h01, "R9 rdata_oe during read");
   endtask

   task automatic t_cfg98;
      logic [W-1:0] d; logic oe;
      bus_write(2'd3, 8'h98);
      check(pa_oe, 8'h00, "R3 0x98 port A input");
      check(pb_oe, 8'hFF, "R3 0x98 port B output");
      check(pc_oe, 8'h0F, "R3 0x98 port C split");
      bus_read(2'd3, d, oe);
      check(d, 8'h98, "R10 readback 0x98");
   endtask

   task automatic t_port_io;
      logic [W-1:0] d; logic oe;
      bus_write(2'd1, 8'hA5);
      check(pb_out, 8'hA5, "R7 port B latch drives");
      check(pa_out, 8'h00, "R2 port A untouched by B write");
      bus_read(2'd1, d, oe);
      check(d, 8'hA5, "R8 output port reads latch");
      bus_write(2'd2, 8'h3C);
      check(pc_out, 8'h3C, "R7 R2 port C both halves written");
      pc_in = 8'hE7;
      pa_in = 8'h5A;
      repeat (3) @(negedge clk);
      bus_read(2'd2, d, oe);
      check(d, 8'hEC, "R8 port C upper pin lower latch");
      bus_read(2'd0, d, oe);
      check(d, 8'h5A, "R8 input port reads pins");
   endtask

   task automatic t_sync_latency;
      logic [W-1:0] d; logic oe;
      @(negedge clk);
      pa_in = 8'h11;
      bus_read(2'd0, d, oe);
      check(d, 8'h5A, "R8 one edge after pin change still old");
      bus_read(2'd0, d, oe);
      check(d, 8'h11, "R8 two edges after pin change new");
   endtask

   task automatic t_ignored_ctrl;
      logic [W-1:0] d; logic oe;
      bus_write(2'd3, 8'h12);
      bus_read(2'd3, d, oe);
      check(d, 8'h98, "R4 no set flag keeps config");
      check(pb_out, 8'hA5, "R4 no set flag keeps latch");
      bus_write(2'd3, 8'hB8);
      bus_read(2'd3, d, oe);
      check(d, 8'h98, "R5 group A mode 1 ignored");
      bus_write(2'd3, 8'h9C);
      bus_read(2'd3, d, oe);
      check(d, 8'h98, "R5 group B mode 1 ignored");
      check(pb_out, 8'hA5, "R5 latch kept");
      check(pb_oe, 8'hFF, "R5 oe kept");
   endtask

   task automatic t_cs_gate;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b0; rd_n = 1'b0; addr = 2'd1; wdata = 8'hFF;
      #1;
      check({7'd0, rdata_oe}, 8'h00, "R9 no read drive unselected");
      check(rdata, 8'h00, "R9 rdata zero unselected");
      @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1;
      check(pb_out, 8'hA5, "R9 write ignored unselected");
   endtask

   task automatic t_cfg82;
      logic [W-1:0] d; logic oe;
      bus_write(2'd3, 8'h82);
      check(pb_out, 8'h00, "R6 port B latch cleared");
      check(pc_out, 8'h00, "R6 port C latch cleared");
      check(pa_oe, 8'hFF, "R3 0x82 port A output");
      check(pb_oe, 8'h00, "R3 0x82 port B input");
      check(pc_oe, 8'hFF, "R3 0x82 port C output");
      bus_read(2'd3, d, oe);
      check(d, 8'h82, "R10 readback 0x82");
      bus_write(2'd0, 8'h77);
      check(pa_out, 8'h77, "R7 port A latch");
      bus_read(2'd0, d, oe);
      check(d, 8'h77, "R8 port A output reads latch");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg98();
      t_port_io();
      t_sync_latency();
      t_ignored_ctrl();
      t_cs_gate();
      t_cfg82();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule